// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This block lets several processors on a chip hand 32-bit words to each other through small hardware queues. Each queue has three memory-mapped registers: one message port (a write pushes a word in, a read pops the oldest word out), one fullness flag, and one count of waiting words. A sender pushes words into a queue. A receiver polls the count or waits for an interrupt, and then pops.

Every queue raises two events. A new-message event fires on each accepted push. A not-full event fires when a pop frees a slot in a queue that was full. Both events go to every user's pending register. Each user also has its own mask register, which selects the events that drive that user's interrupt line. Software clears pending bits by writing ones to them.

The register interface has a separate read address and write address, so one read and one write can complete in the same cycle. Read data is registered.

Top module: `mbx_top`

## Requirements
- R1: After reset every queue is empty (count 0, fullness 0). All pending and mask registers read 0, and every interrupt line is low.
- R2: Offset 0x000 reads {major[7:4], minor[3:0]} with the upper bits zero (0x10 with the default parameters). Writes to it have no effect.
- R3: A write to 0x040+4*m pushes a word into queue m, and a read there pops words oldest-first. Offset 0x0C0+4*m returns the number of waiting words.
- R4: Each queue holds 4 words. Offset 0x080+4*m reads 1 when queue m holds 4 words and 0 otherwise. A push to a full queue is discarded.
- R5: A read of an empty queue's message port returns 0. It leaves the count unchanged and raises no event.
- R6: Every accepted push into queue m sets pending bit 2*m in every user's pending register.
- R7: A pop that takes queue m from full to not-full sets pending bit 2*m+1 in every user's pending register.
- R8: User u's pending register is at 0x100+8*u. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. A read in the next cycle returns the updated value.
- R9: User u's mask register is at 0x104+8*u and reads back as written. irq[u] is high exactly when some bit is set in both that user's pending register and its mask register.
- R10: When an event sets a pending bit in the same cycle that a write of 1 clears it, the bit ends up set.
- R11: Reads of unaligned or undefined offsets (an address with a non-zero low two bits, a queue index of 4 or above, 0x120 and up, writes to fullness or count registers) return 0. Writes to those offsets, and to the fullness and count registers, change nothing.
- R12: The mask registers are independent. An event pending in several users raises irq only on the users whose mask bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 9 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a read of a message port pops |
| rd_addr | input | 9 | Byte address of the read |
| rd_data | output | 32 | Registered read data, held until the next read |
| irq | output | NUM_USER | One interrupt line per user |

## Verification
A read strobe presented before rising edge k returns its data in rd_data directly after edge k. Any pop caused by that read, and any event it raises, also happen at edge k. A write takes effect at the edge that samples it, and pending bits, masks and the irq lines show the change straight after that edge. The bench drives on falling edges and samples on the next falling edge. A one-cycle read pipeline flag tells the monitor which falling edge carries the data of each queued expectation. Concurrent pop-and-clear is driven in a single cycle to exercise the set-over-clear priority.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 9;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_REV,
        RG_MSG,
        RG_FULL,
        RG_CNT,
        RG_PEND,
        RG_MASK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] idx;
    } reg_sel_t;

    // Map a byte address onto a register kind and a queue or user index.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int n_mbox,
                                             input int n_user);
        reg_sel_t s;
        s.kind = RG_NONE;
        s.idx  = a[5:2];
        if (a[1:0] == 2'b00) begin
            case (a[8:6])
                3'd0: if (a[5:2] == 4'd0) s.kind = RG_REV;
                3'd1: if (int'(a[5:2]) < n_mbox) s.kind = RG_MSG;
                3'd2: if (int'(a[5:2]) < n_mbox) s.kind = RG_FULL;
                3'd3: if (int'(a[5:2]) < n_mbox) s.kind = RG_CNT;
                3'd4: begin
                    s.idx = {2'b00, a[4:3]};
                    if (!a[5] && (int'(a[4:3]) < n_user))
                        s.kind = a[2] ? RG_MASK : RG_PEND;
                end
                default: s.kind = RG_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/mbx_queue.sv
module mbx_queue #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              ev_new,
    output logic              ev_free
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic              empty, take_push, take_pop;

    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign take_push = push && !full;
    assign take_pop  = pop && !empty;
    assign head      = empty ? '0 : mem[rptr];
    assign ev_new    = take_push;
    assign ev_free   = take_pop && full;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (take_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (take_push) wptr <= bump(wptr);
            if (take_pop)  rptr <= bump(rptr);
            case ({take_push, take_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
    parameter int EV_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [EV_W-1:0] events,
    input  logic            clr_wr,
    input  logic            mask_wr,
    input  logic [EV_W-1:0] wdata,
    output logic [EV_W-1:0] pending,
    output logic [EV_W-1:0] mask,
    output logic            irq
);
    logic [EV_W-1:0] clr_bits;

    assign clr_bits = clr_wr ? wdata : '0;
    assign irq      = |(pending & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            mask    <= '0;
        end else begin
            // new events win over a same-cycle clear
            pending <= (pending & ~clr_bits) | events;
            if (mask_wr) mask <= wdata;
        end
    end
endmodule

// File: rtl/mbx_top.sv
module mbx_top
    import mbx_pkg::*;
#(
    parameter int         NUM_MBOX  = 4,
    parameter int         NUM_USER  = 4,
    parameter int         DEPTH     = 4,
    parameter logic [3:0] REV_MAJOR = 4'h1,
    parameter logic [3:0] REV_MINOR = 4'h0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [8:0]          wr_addr,
    input  logic [31:0]         wr_data,
    input  logic                rd_en,
    input  logic [8:0]          rd_addr,
    output logic [31:0]         rd_data,
    output logic [NUM_USER-1:0] irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int EV_W  = 2 * NUM_MBOX;

    reg_sel_t wsel, rsel;
    assign wsel = decode_addr(wr_addr, NUM_MBOX, NUM_USER);
    assign rsel = decode_addr(rd_addr, NUM_MBOX, NUM_USER);

    logic [NUM_MBOX-1:0][DATA_W-1:0] q_head;
    logic [NUM_MBOX-1:0][CNT_W-1:0]  q_cnt;
    logic [NUM_MBOX-1:0]             q_full;
    logic [EV_W-1:0]                 ev;
    logic [NUM_USER-1:0][EV_W-1:0]   u_stat;
    logic [NUM_USER-1:0][EV_W-1:0]   u_en;

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_q
        logic push, pop;
        assign push = wr_en && (wsel.kind == RG_MSG) && (wsel.idx == 4'(m));
        assign pop  = rd_en && (rsel.kind == RG_MSG) && (rsel.idx == 4'(m));
        mbx_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_queue (
            .clk       (clk),
            .rst       (rst),
            .push      (push),
            .push_data (wr_data),
            .pop       (pop),
            .head      (q_head[m]),
            .count     (q_cnt[m]),
            .full      (q_full[m]),
            .ev_new    (ev[2*m]),
            .ev_free   (ev[2*m+1])
        );
    end

    for (genvar u = 0; u < NUM_USER; u++) begin : g_u
        logic clr_wr, mask_wr;
        assign clr_wr  = wr_en && (wsel.kind == RG_PEND) && (wsel.idx == 4'(u));
        assign mask_wr = wr_en && (wsel.kind == RG_MASK) && (wsel.idx == 4'(u));
        mbx_user_irq #(.EV_W(EV_W)) u_irq (
            .clk     (clk),
            .rst     (rst),
            .events  (ev),
            .clr_wr  (clr_wr),
            .mask_wr (mask_wr),
            .wdata   (wr_data[EV_W-1:0]),
            .pending (u_stat[u]),
            .mask    (u_en[u]),
            .irq     (irq[u])
        );
    end

    logic [DATA_W-1:0] rmux;
    always_comb begin
        rmux = '0;
        case (rsel.kind)
            RG_REV: rmux = {24'd0, REV_MAJOR, REV_MINOR};
            RG_MSG, RG_FULL, RG_CNT: begin
                for (int m = 0; m < NUM_MBOX; m++) begin
                    if (rsel.idx == 4'(m)) begin
                        if (rsel.kind == RG_MSG)       rmux = q_head[m];
                        else if (rsel.kind == RG_FULL) rmux = DATA_W'(q_full[m]);
                        else                           rmux = DATA_W'(q_cnt[m]);
                    end
                end
            end
            RG_PEND, RG_MASK: begin
                for (int u = 0; u < NUM_USER; u++) begin
                    if (rsel.idx == 4'(u))
                        rmux = (rsel.kind == RG_PEND) ? DATA_W'(u_stat[u]) : DATA_W'(u_en[u]);
                end
            end
            default: rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rmux;
    end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int         NUM_MBOX  = 4,
    parameter int         NUM_USER  = 4,
    parameter int         DEPTH     = 4,
    parameter logic [3:0] REV_MAJOR = 4'h1,
    parameter logic [3:0] REV_MINOR = 4'h0,
    parameter int         CNT_W     = $clog2(DEPTH + 1),
    parameter int         EV_W      = 2 * NUM_MBOX
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           wr_en,
    input logic [8:0]                     wr_addr,
    input logic                           rd_en,
    input logic [8:0]                     rd_addr,
    input logic [31:0]                    rd_data,
    input logic [NUM_USER-1:0]            irq,
    input logic [NUM_MBOX-1:0][CNT_W-1:0] q_cnt,
    input logic [NUM_USER-1:0][EV_W-1:0]  u_stat,
    input logic [NUM_USER-1:0][EV_W-1:0]  u_en
);
    // R1: the cycle after reset is applied, queues are empty and lines low
    assert_reset_clean_R1: assert property (@(posedge clk)
        rst |=> (q_cnt == '0 && irq == '0));

    assert_rev_value_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == 9'h000) |=> (rd_data == {24'd0, REV_MAJOR, REV_MINOR}));

    assert_undef_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == 9'h120) |=> (rd_data == 32'd0));

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mq
        localparam logic [8:0] MSG_A = 9'(64 + 4 * m);

        assert_fill_bound_R4: assert property (@(posedge clk) disable iff (rst)
            q_cnt[m] <= CNT_W'(DEPTH));

        assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == MSG_A && q_cnt[m] == CNT_W'(DEPTH)
             && !(rd_en && rd_addr == MSG_A)) |=> (q_cnt[m] == CNT_W'(DEPTH)));

        assert_empty_pop_zero_R5: assert property (@(posedge clk) disable iff (rst)
            (rd_en && rd_addr == MSG_A && q_cnt[m] == '0
             && !(wr_en && wr_addr == MSG_A)) |=> (rd_data == 32'd0 && q_cnt[m] == '0));

        for (genvar u = 0; u < NUM_USER; u++) begin : g_mu
            assert_newmsg_set_R6: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_addr == MSG_A && q_cnt[m] < CNT_W'(DEPTH)) |=> u_stat[u][2*m]);

            assert_notfull_set_R7: assert property (@(posedge clk) disable iff (rst)
                (rd_en && rd_addr == MSG_A && q_cnt[m] == CNT_W'(DEPTH)) |=> u_stat[u][2*m+1]);
        end
    end

    for (genvar u = 0; u < NUM_USER; u++) begin : g_ui
        assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
            irq[u] |-> (u_en[u] != '0 && u_stat[u] != '0));
    end
endmodule

bind mbx_top mbx_checker #(
    .NUM_MBOX  (NUM_MBOX),
    .NUM_USER  (NUM_USER),
    .DEPTH     (DEPTH),
    .REV_MAJOR (REV_MAJOR),
    .REV_MINOR (REV_MINOR)
) u_mbx_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq     (irq),
    .q_cnt   (q_cnt),
    .u_stat  (u_stat),
    .u_en    (u_en)
);

// File: tb/tb_mbx_top.sv
`timescale 1ns/1ps
module tb_mbx_top;
    localparam int NU = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [8:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [8:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NU-1:0] irq;

    mbx_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= rd_en;

    // monitor: the read data for a strobe sampled at edge k is checked at the following falling edge
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (rd_data !== e) begin
                n_fail++;
                $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
            end
        end
    end

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [31:0] e, input string t);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rdwr(input logic [8:0] wa, input logic [31:0] d,
                        input logic [8:0] ra, input logic [31:0] e, input string t);
        wr_en = 1'b1; wr_addr = wa; wr_data = d;
        rd_en = 1'b1; rd_addr = ra;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic check_irq(input logic [NU-1:0] e, input string t);
        n_tests++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq=%b expected=%b", t, irq, e);
        end
    endtask

    function automatic logic [8:0] a_msg(input int m);  return 9'(64 + 4 * m);  endfunction
    function automatic logic [8:0] a_full(input int m); return 9'(128 + 4 * m); endfunction
    function automatic logic [8:0] a_cnt(input int m);  return 9'(192 + 4 * m); endfunction
    function automatic logic [8:0] a_pend(input int u); return 9'(256 + 8 * u); endfunction
    function automatic logic [8:0] a_mask(input int u); return 9'(260 + 8 * u); endfunction

    logic done = 1'b0;

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(a_cnt(0), 0, "R1 count");
        rd(a_full(0), 0, "R1 fullness");
        rd(a_pend(0), 0, "R1 pending");
        rd(a_mask(3), 0, "R1 mask");
        check_irq('0, "R1 irq");

        // R2 revision, write ignored
        rd(9'h000, 32'h10, "R2 revision");
        wr(9'h000, 32'hFFFF_FFFF);
        rd(9'h000, 32'h10, "R2 revision after write");

        // R9 mask alone raises nothing
        wr(a_mask(0), 32'h1);
        check_irq('0, "R9 mask without pending");

        // R6 / R9 push raises new-message event
        wr(a_msg(0), 32'hA1);
        check_irq(4'b0001, "R9 irq on user0");
        rd(a_pend(0), 32'h1, "R6 pending user0");
        rd(a_pend(3), 32'h1, "R6 pending user3");
        rd(a_cnt(0), 1, "R3 count one");
        rd(a_mask(0), 32'h1, "R9 mask readback");

        // R4 fill and overflow discard
        wr(a_msg(0), 32'hA2);
        wr(a_msg(0), 32'hA3);
        wr(a_msg(0), 32'hA4);
        rd(a_cnt(0), 4, "R3 count four");
        rd(a_full(0), 1, "R4 full flag");
        wr(a_msg(0), 32'hA5);
        rd(a_cnt(0), 4, "R4 push to full dropped");

        // R8 write-one-to-clear
        wr(a_pend(0), 32'h0);
        rd(a_pend(0), 32'h1, "R8 zero write keeps bit");
        wr(a_pend(0), 32'h1);
        rd(a_pend(0), 32'h0, "R8 one write clears");
        check_irq('0, "R9 irq drops after clear");

        // R3 / R7 drain in order
        rd(a_msg(0), 32'hA1, "R3 pop 1");
        rd(a_pend(0), 32'h2, "R7 not-full event");
        rd(a_full(0), 0, "R4 full flag clears");
        rd(a_msg(0), 32'hA2, "R3 pop 2");
        rd(a_msg(0), 32'hA3, "R3 pop 3");
        rd(a_msg(0), 32'hA4, "R4 pop 4 (A5 dropped)");
        rd(a_cnt(0), 0, "R3 count zero");

        // R5 empty read
        wr(a_pend(0), 32'h2);
        rd(a_msg(0), 32'h0, "R5 empty read zero");
        rd(a_cnt(0), 0, "R5 count unchanged");
        rd(a_pend(0), 32'h0, "R5 no event");

        // R10 set beats clear
        wr(a_msg(1), 32'hB1);
        wr(a_msg(1), 32'hB2);
        wr(a_msg(1), 32'hB3);
        wr(a_msg(1), 32'hB4);
        wr(a_pend(0), 32'h4);
        rd(a_pend(0), 32'h0, "R8 clear mbox1 newmsg");
        rdwr(a_pend(0), 32'h8, a_msg(1), 32'hB1, "R10 pop while clearing");
        rd(a_pend(0), 32'h8, "R10 set wins");
        rd(a_cnt(1), 3, "R3 count mbox1");

        // R12 per-user masks
        wr(a_mask(2), 32'h8);
        check_irq(4'b0100, "R12 only user2");
        rd(a_pend(1), 32'h0F, "R12 user1 pending");
        wr(a_pend(2), 32'h0F);
        check_irq(4'b0000, "R12 user2 cleared");
        rd(a_pend(2), 32'h0, "R8 user2 cleared");

        // R11 undefined offsets
        rd(9'h03C, 0, "R11 gap read");
        rd(9'h050, 0, "R11 queue index 4");
        rd(9'h120, 0, "R11 past user space");
        rd(9'h1FC, 0, "R11 top of space");
        rd(9'h041, 0, "R11 unaligned");
        wr(9'h041, 32'h66);
        wr(9'h050, 32'h55);
        wr(a_cnt(0), 32'h7);
        wr(a_full(0), 32'h1);
        wr(9'h124, 32'hFF);
        rd(a_cnt(0), 0, "R11 writes ignored count");
        rd(a_pend(0), 32'h8, "R11 writes ignored pending");
        check_irq(4'b0000, "R11 irq unchanged");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule